// File: doc/BRIEF.md
# Function Call and Return Event Trigger

This block sits beside a processor core and watches the stream of retired instructions without ever holding the core back. Each of a bank of trigger slots is configured with a program-counter value and a kind. An exact slot produces a primary event when the retired PC equals its value. A return slot detects the moment a chosen function hands control back to its caller. The entry PC of the function is one comparison and the resume address is another, and the resume address differs from one call to the next. On entry the block pushes the caller's link-register value onto a small internal return-address stack. A later retire whose PC equals the top of that stack closes the call and raises the event.

A shadow copy of the low registers of the core is kept current by snooping the register writeback port. Every event carries a fixed generator identifier, the index of the trigger slot, the retired PC and a snapshot of the shadow registers, masked per slot. Events leave on a valid/ready stream. When several slots fire together they are emitted one after another, lowest slot first. Anything that fires while an earlier group is still waiting is counted as dropped and discarded.

Top module: `callret_trigger`

## Requirements
- R1: When `rt_valid` is high and `rt_pc` equals the PC of an enabled exact slot, the next cycle presents an event with `evt_trig` equal to that slot, `evt_pc` equal to the retired PC and `evt_gen_id` equal to the `GEN_ID` parameter (default 0x2A).
- R2: No event appears for a retire whose PC matches no enabled slot, for a disabled slot, or while `rt_valid` is low.
- R3: A retire at the entry PC of an enabled return slot produces no event and pushes `rt_link` together with the slot index onto the return-address stack.
- R4: A retire whose PC equals the top stack address pops that entry and, one cycle later, presents an event for the slot stored with it (if that slot is still enabled), with `evt_pc` set to the retired PC. A popped address no longer matches.
- R5: Only the top stack entry is compared, so nested calls close in last-in, first-out order.
- R6: A push onto a full stack (`STK_DEPTH`, default 4) is discarded, and `stk_overflow` goes high and stays high until reset.
- R7: A writeback to register index 1..NREG-1 updates the shadow copy. Register 0 always reads as zero. The snapshot taken on a trigger holds the values written in earlier cycles, not a writeback in the same cycle.
- R8: `evt_regs` holds register r in bits [r*XLEN +: XLEN]. The field is zero unless bit r of the emitted slot's register-select mask is set.
- R9: Slots that fire in the same cycle are emitted one per accepted handshake in rising index order. While `evt_valid` is high and `evt_ready` low, the event outputs hold steady.
- R10: Hits that arrive while an earlier group is not fully drained (counting a handshake in that same cycle) are discarded. `drop_count` rises by the number of discarded hits and saturates at its maximum value. A group whose last event is accepted in the same cycle lets the new hits in.
- R11: Configuration writes use address {slot, sel}, where sel is the low two bits: sel 0 is control (bit 0 enable, bit 1 kind: 0 exact, 1 return), sel 1 is the PC and sel 2 is the register-select mask. Writes naming a slot at or above NTRIG change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | $clog2(NTRIG)+2 | Configuration address {slot, sel} |
| cfg_wdata | input | XLEN | Configuration write data |
| rt_valid | input | 1 | An instruction retires this cycle |
| rt_pc | input | XLEN | PC of the retiring instruction |
| rt_link | input | XLEN | Current link-register value |
| wb_valid | input | 1 | Register writeback this cycle |
| wb_idx | input | RF_AW | Writeback register index |
| wb_data | input | XLEN | Writeback data |
| evt_valid | output | 1 | Event available |
| evt_ready | input | 1 | Consumer accepts the event |
| evt_gen_id | output | GID_W | Generator identifier (event type) |
| evt_trig | output | $clog2(NTRIG) | Index of the slot that fired |
| evt_pc | output | XLEN | Retired PC at the trigger instant |
| evt_regs | output | NREG*XLEN | Masked shadow register snapshot |
| drop_count | output | DCNT_W | Saturating count of discarded hits |
| stk_overflow | output | 1 | Sticky return-stack overflow flag |

## Verification
Every exact slot is swept in turn with a unique PC. Each sweep shows that the slot index and PC track the comparator that matched, and that no slot aliases another. Unmatched, disabled and out-of-range-slot patterns show that silence comes from the enable and the address decode, not from a missing comparator. Shared-PC groups are run with and without back-pressure. These separate ordering from holding behaviour, show how the drop counter grows and saturates, and show the boundary where a group drains in the same cycle that new hits arrive. Call and return patterns are run single, nested, and pushed past the stack depth. They tell LIFO matching apart from any-entry matching and show which push is lost on overflow. Register patterns cover full, sparse and same-cycle writes, which separate masking, the register-0 rule and the snapshot timing.

// File: rtl/cr_pkg.sv
package cr_pkg;
    // Trigger slot kinds (control bit 1)
    typedef enum logic {
        TK_EXACT  = 1'b0,
        TK_RETURN = 1'b1
    } trig_kind_e;

    // Configuration word selector (low two address bits)
    localparam logic [1:0] SEL_CTRL = 2'd0;
    localparam logic [1:0] SEL_PC   = 2'd1;
    localparam logic [1:0] SEL_MASK = 2'd2;
endpackage

// File: rtl/cr_shadow_rf.sv
module cr_shadow_rf #(
    parameter int unsigned XLEN  = 32,
    parameter int unsigned NREG  = 8,
    parameter int unsigned RF_AW = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wb_valid,
    input  logic [RF_AW-1:0]     wb_idx,
    input  logic [XLEN-1:0]      wb_data,
    output logic [NREG*XLEN-1:0] regs_o
);
    typedef struct packed {
        logic [NREG-1:0][XLEN-1:0] r;
    } rf_st_t;

    rf_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 1; i < NREG; i++) begin
            if (wb_valid && (wb_idx == RF_AW'(i))) begin
                st_d.r[i] = wb_data;
            end
        end
        st_d.r[0] = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign regs_o = st_q.r;
endmodule

// File: rtl/cr_ret_stack.sv
module cr_ret_stack #(
    parameter int unsigned XLEN  = 32,
    parameter int unsigned DEPTH = 4,
    parameter int unsigned TAG_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pc_valid_i,
    input  logic [XLEN-1:0]  pc_i,
    input  logic             push_i,
    input  logic [XLEN-1:0]  push_addr_i,
    input  logic [TAG_W-1:0] push_tag_i,
    output logic             hit_o,
    output logic [TAG_W-1:0] hit_tag_o,
    output logic             ovf_o
);
    localparam int unsigned CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][XLEN-1:0]  addr;
        logic [DEPTH-1:0][TAG_W-1:0] tag;
        logic [CW-1:0]               cnt;
        logic                        ovf;
    } stk_st_t;

    stk_st_t st_d, st_q;
    logic [XLEN-1:0]  top_addr;
    logic [TAG_W-1:0] top_tag;
    logic [CW-1:0]    base;

    always_comb begin
        top_addr = '0;
        top_tag  = '0;
        for (int d = 0; d < DEPTH; d++) begin
            if (st_q.cnt == CW'(d + 1)) begin
                top_addr = st_q.addr[d];
                top_tag  = st_q.tag[d];
            end
        end
        hit_o     = pc_valid_i && (st_q.cnt != '0) && (top_addr == pc_i);
        hit_tag_o = top_tag;

        st_d = st_q;
        base = hit_o ? (st_q.cnt - CW'(1)) : st_q.cnt;
        st_d.cnt = base;
        if (push_i) begin
            if (base == CW'(DEPTH)) begin
                st_d.ovf = 1'b1;
            end else begin
                for (int d = 0; d < DEPTH; d++) begin
                    if (base == CW'(d)) begin
                        st_d.addr[d] = push_addr_i;
                        st_d.tag[d]  = push_tag_i;
                    end
                end
                st_d.cnt = base + CW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ovf_o = st_q.ovf;
endmodule

// File: rtl/cr_evt_queue.sv
module cr_evt_queue #(
    parameter int unsigned NTRIG  = 12,
    parameter int unsigned XLEN   = 32,
    parameter int unsigned NREG   = 8,
    parameter int unsigned DCNT_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NTRIG-1:0]        hits_i,
    input  logic [XLEN-1:0]         pc_i,
    input  logic [NREG*XLEN-1:0]    regs_i,
    input  logic                    ready_i,
    output logic                    valid_o,
    output logic [$clog2(NTRIG)-1:0] trig_o,
    output logic [XLEN-1:0]         pc_o,
    output logic [NREG*XLEN-1:0]    regs_o,
    output logic [DCNT_W-1:0]       drop_o
);
    localparam int unsigned TIDX_W = $clog2(NTRIG);
    localparam int unsigned PC_W   = $clog2(NTRIG + 1);
    localparam int unsigned SUM_W  = DCNT_W + PC_W;

    typedef struct packed {
        logic [NTRIG-1:0]     pend;
        logic [XLEN-1:0]      pc;
        logic [NREG*XLEN-1:0] regs;
        logic [DCNT_W-1:0]    drop;
    } q_st_t;

    q_st_t st_d, st_q;
    logic [TIDX_W-1:0] sel;
    logic [NTRIG-1:0]  left;
    logic [PC_W-1:0]   nhits;
    logic [SUM_W-1:0]  sum;

    always_comb begin
        sel = '0;
        for (int i = NTRIG - 1; i >= 0; i--) begin
            if (st_q.pend[i]) sel = TIDX_W'(i);
        end
        valid_o = |st_q.pend;

        left = st_q.pend;
        if (valid_o && ready_i) begin
            for (int i = 0; i < NTRIG; i++) begin
                if (sel == TIDX_W'(i)) left[i] = 1'b0;
            end
        end

        nhits = '0;
        for (int i = 0; i < NTRIG; i++) begin
            nhits = nhits + PC_W'(hits_i[i]);
        end
        sum = SUM_W'(st_q.drop) + SUM_W'(nhits);

        st_d      = st_q;
        st_d.pend = left;
        if (hits_i != '0) begin
            if (left == '0) begin
                st_d.pend = hits_i;
                st_d.pc   = pc_i;
                st_d.regs = regs_i;
            end else if (sum > SUM_W'({DCNT_W{1'b1}})) begin
                st_d.drop = '1;
            end else begin
                st_d.drop = sum[DCNT_W-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign trig_o = sel;
    assign pc_o   = st_q.pc;
    assign regs_o = st_q.regs;
    assign drop_o = st_q.drop;
endmodule

// File: rtl/callret_trigger.sv
module callret_trigger #(
    parameter int unsigned     XLEN      = 32,
    parameter int unsigned     NREG      = 8,
    parameter int unsigned     NTRIG     = 12,
    parameter int unsigned     STK_DEPTH = 4,
    parameter int unsigned     DCNT_W    = 8,
    parameter int unsigned     GID_W     = 8,
    parameter int unsigned     RF_AW     = 5,
    parameter logic [GID_W-1:0] GEN_ID   = 8'h2A
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cfg_we,
    input  logic [$clog2(NTRIG)+1:0]   cfg_addr,
    input  logic [XLEN-1:0]            cfg_wdata,
    input  logic                       rt_valid,
    input  logic [XLEN-1:0]            rt_pc,
    input  logic [XLEN-1:0]            rt_link,
    input  logic                       wb_valid,
    input  logic [RF_AW-1:0]           wb_idx,
    input  logic [XLEN-1:0]            wb_data,
    output logic                       evt_valid,
    input  logic                       evt_ready,
    output logic [GID_W-1:0]           evt_gen_id,
    output logic [$clog2(NTRIG)-1:0]   evt_trig,
    output logic [XLEN-1:0]            evt_pc,
    output logic [NREG*XLEN-1:0]       evt_regs,
    output logic [DCNT_W-1:0]          drop_count,
    output logic                       stk_overflow
);
    import cr_pkg::*;

    localparam int unsigned TIDX_W = $clog2(NTRIG);

    typedef struct packed {
        logic            en;
        trig_kind_e      kind;
        logic [XLEN-1:0] pc;
        logic [NREG-1:0] mask;
    } slot_cfg_t;

    typedef struct packed {
        slot_cfg_t [NTRIG-1:0] slot;
    } top_st_t;

    top_st_t st_d, st_q;

    logic [TIDX_W-1:0]    widx;
    logic [1:0]           wsel;
    logic [NTRIG-1:0]     exact_hit;
    logic [NTRIG-1:0]     entry_hit;
    logic [NTRIG-1:0]     hits;
    logic                 push;
    logic [TIDX_W-1:0]    push_tag;
    logic                 ret_hit;
    logic [TIDX_W-1:0]    ret_tag;
    logic [NREG*XLEN-1:0] shadow;
    logic [NREG*XLEN-1:0] raw_regs;
    logic [NREG-1:0]      out_mask;

    // Configuration bank
    always_comb begin
        widx = cfg_addr[TIDX_W+1:2];
        wsel = cfg_addr[1:0];
        st_d = st_q;
        for (int i = 0; i < NTRIG; i++) begin
            if (cfg_we && (widx == TIDX_W'(i))) begin
                case (wsel)
                    SEL_CTRL: begin
                        st_d.slot[i].en   = cfg_wdata[0];
                        st_d.slot[i].kind = trig_kind_e'(cfg_wdata[1]);
                    end
                    SEL_PC:   st_d.slot[i].pc   = cfg_wdata;
                    SEL_MASK: st_d.slot[i].mask = cfg_wdata[NREG-1:0];
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // Comparators, one pair per slot
    for (genvar g = 0; g < NTRIG; g++) begin : g_cmp
        logic pc_eq;
        assign pc_eq        = rt_valid && st_q.slot[g].en && (st_q.slot[g].pc == rt_pc);
        assign exact_hit[g] = pc_eq && (st_q.slot[g].kind == TK_EXACT);
        assign entry_hit[g] = pc_eq && (st_q.slot[g].kind == TK_RETURN);
    end

    always_comb begin
        push     = |entry_hit;
        push_tag = '0;
        for (int i = NTRIG - 1; i >= 0; i--) begin
            if (entry_hit[i]) push_tag = TIDX_W'(i);
        end
        hits = exact_hit;
        for (int i = 0; i < NTRIG; i++) begin
            if (ret_hit && (ret_tag == TIDX_W'(i)) && st_q.slot[i].en) begin
                hits[i] = 1'b1;
            end
        end
    end

    cr_ret_stack #(
        .XLEN  (XLEN),
        .DEPTH (STK_DEPTH),
        .TAG_W (TIDX_W)
    ) u_stack (
        .clk         (clk),
        .rst_n       (rst_n),
        .pc_valid_i  (rt_valid),
        .pc_i        (rt_pc),
        .push_i      (push),
        .push_addr_i (rt_link),
        .push_tag_i  (push_tag),
        .hit_o       (ret_hit),
        .hit_tag_o   (ret_tag),
        .ovf_o       (stk_overflow)
    );

    cr_shadow_rf #(
        .XLEN  (XLEN),
        .NREG  (NREG),
        .RF_AW (RF_AW)
    ) u_shadow (
        .clk      (clk),
        .rst_n    (rst_n),
        .wb_valid (wb_valid),
        .wb_idx   (wb_idx),
        .wb_data  (wb_data),
        .regs_o   (shadow)
    );

    cr_evt_queue #(
        .NTRIG  (NTRIG),
        .XLEN   (XLEN),
        .NREG   (NREG),
        .DCNT_W (DCNT_W)
    ) u_queue (
        .clk     (clk),
        .rst_n   (rst_n),
        .hits_i  (hits),
        .pc_i    (rt_pc),
        .regs_i  (shadow),
        .ready_i (evt_ready),
        .valid_o (evt_valid),
        .trig_o  (evt_trig),
        .pc_o    (evt_pc),
        .regs_o  (raw_regs),
        .drop_o  (drop_count)
    );

    // Per-slot register-select mask applied on the way out
    always_comb begin
        out_mask = '0;
        for (int i = 0; i < NTRIG; i++) begin
            if (evt_trig == TIDX_W'(i)) out_mask = st_q.slot[i].mask;
        end
    end

    for (genvar r = 0; r < NREG; r++) begin : g_mask
        assign evt_regs[r*XLEN +: XLEN] = out_mask[r] ? raw_regs[r*XLEN +: XLEN] : '0;
    end

    assign evt_gen_id = GEN_ID;
endmodule

// File: rtl/callret_trigger_chk.sv
module callret_trigger_chk #(
    parameter int unsigned XLEN   = 32,
    parameter int unsigned NREG   = 8,
    parameter int unsigned NTRIG  = 12,
    parameter int unsigned DCNT_W = 8
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     rt_valid,
    input logic                     evt_valid,
    input logic                     evt_ready,
    input logic [$clog2(NTRIG)-1:0] evt_trig,
    input logic [XLEN-1:0]          evt_pc,
    input logic [NREG*XLEN-1:0]     evt_regs,
    input logic [DCNT_W-1:0]        drop_count,
    input logic                     stk_overflow
);
    p_stall_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && !evt_ready) |=> (evt_valid && $stable(evt_trig) && $stable(evt_pc)));

    p_trig_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
        evt_valid |-> (int'(evt_trig) < NTRIG));

    p_no_overflow_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        stk_overflow |=> stk_overflow);

    p_drop_monotonic_r10: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (drop_count >= $past(drop_count)));

    p_reg0_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        evt_valid |-> (evt_regs[XLEN-1:0] == '0));

    p_quiet_no_retire_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!rt_valid && !evt_valid) |=> !evt_valid);
endmodule

bind callret_trigger callret_trigger_chk #(
    .XLEN   (XLEN),
    .NREG   (NREG),
    .NTRIG  (NTRIG),
    .DCNT_W (DCNT_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .rt_valid     (rt_valid),
    .evt_valid    (evt_valid),
    .evt_ready    (evt_ready),
    .evt_trig     (evt_trig),
    .evt_pc       (evt_pc),
    .evt_regs     (evt_regs),
    .drop_count   (drop_count),
    .stk_overflow (stk_overflow)
);

// File: tb/callret_trigger_tb.sv
module callret_trigger_tb;
    localparam int CLK_P = 10;
    localparam int XLEN  = 32;
    localparam int NREG  = 8;
    localparam int NTRIG = 12;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 cfg_we = 1'b0;
    logic [5:0]           cfg_addr = '0;
    logic [XLEN-1:0]      cfg_wdata = '0;
    logic                 rt_valid = 1'b0;
    logic [XLEN-1:0]      rt_pc = '0;
    logic [XLEN-1:0]      rt_link = '0;
    logic                 wb_valid = 1'b0;
    logic [4:0]           wb_idx = '0;
    logic [XLEN-1:0]      wb_data = '0;
    logic                 evt_valid;
    logic                 evt_ready = 1'b1;
    logic [7:0]           evt_gen_id;
    logic [3:0]           evt_trig;
    logic [XLEN-1:0]      evt_pc;
    logic [NREG*XLEN-1:0] evt_regs;
    logic [7:0]           drop_count;
    logic                 stk_overflow;

    int n_vec = 0;
    int n_bad = 0;

    callret_trigger u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .rt_valid(rt_valid), .rt_pc(rt_pc),
        .rt_link(rt_link), .wb_valid(wb_valid), .wb_idx(wb_idx),
        .wb_data(wb_data), .evt_valid(evt_valid), .evt_ready(evt_ready),
        .evt_gen_id(evt_gen_id), .evt_trig(evt_trig), .evt_pc(evt_pc),
        .evt_regs(evt_regs), .drop_count(drop_count), .stk_overflow(stk_overflow)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic cfgw(input int slot, input int sel, input logic [XLEN-1:0] d);
        cfg_we = 1'b1; cfg_addr = {4'(slot), 2'(sel)}; cfg_wdata = d;
        step();
        cfg_we = 1'b0;
    endtask

    task automatic wbw(input int r, input logic [XLEN-1:0] d);
        wb_valid = 1'b1; wb_idx = 5'(r); wb_data = d;
        step();
        wb_valid = 1'b0;
    endtask

    task automatic retire(input logic [XLEN-1:0] pc, input logic [XLEN-1:0] link);
        rt_valid = 1'b1; rt_pc = pc; rt_link = link;
        step();
        rt_valid = 1'b0;
    endtask

    function automatic logic [XLEN-1:0] fld(input int r);
        return evt_regs[r*XLEN +: XLEN];
    endfunction

    task automatic expect_evt(input string req, input int t, input logic [XLEN-1:0] pc);
        chk({req, " valid"}, 64'(evt_valid), 64'd1);
        chk({req, " trig"}, 64'(evt_trig), 64'(t));
        chk({req, " pc"}, 64'(evt_pc), 64'(pc));
    endtask

    initial begin
        #(CLK_P * 100000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        // Reset state
        chk("R2 reset valid", 64'(evt_valid), 0);
        chk("R10 reset drop", 64'(drop_count), 0);
        chk("R6 reset overflow", 64'(stk_overflow), 0);

        // R1 / R11: every exact slot with its own PC
        for (int i = 0; i < NTRIG; i++) begin
            cfgw(i, 1, 32'h1000 + 32'(16 * i));
            cfgw(i, 0, 32'h1);
        end
        for (int i = 0; i < NTRIG; i++) begin
            retire(32'h1000 + 32'(16 * i), 0);
            expect_evt("R1 sweep", i, 32'h1000 + 32'(16 * i));
            chk("R1 gen id", 64'(evt_gen_id), 64'h2A);
            step();
            chk("R1 single event", 64'(evt_valid), 0);
        end

        // R2: unmatched PC, disabled slot
        retire(32'h9990, 0);
        chk("R2 unmatched", 64'(evt_valid), 0);
        cfgw(4, 0, 32'h0);
        retire(32'h1040, 0);
        chk("R2 disabled", 64'(evt_valid), 0);

        // R11: slot index beyond NTRIG is ignored
        cfgw(13, 1, 32'h9990);
        cfgw(13, 0, 32'h1);
        retire(32'h9990, 0);
        chk("R11 out-of-range slot", 64'(evt_valid), 0);

        // R7 / R8: shadow registers and masking
        wbw(0, 32'hDEAD);
        for (int r = 1; r < NREG; r++) wbw(r, 32'h100 + 32'(r));
        cfgw(2, 2, 32'hFF);
        retire(32'h1020, 0);
        expect_evt("R8 full mask", 2, 32'h1020);
        chk("R7 reg0 zero", 64'(fld(0)), 0);
        for (int r = 1; r < NREG; r++) chk("R8 full field", 64'(fld(r)), 64'(32'h100 + 32'(r)));
        step();
        cfgw(2, 2, 32'hA4);
        retire(32'h1020, 0);
        for (int r = 0; r < NREG; r++) begin
            if (r == 2 || r == 5 || r == 7) chk("R8 sparse set", 64'(fld(r)), 64'(32'h100 + 32'(r)));
            else chk("R8 sparse clear", 64'(fld(r)), 0);
        end
        step();
        cfgw(2, 2, 32'hFF);
        rt_valid = 1'b1; rt_pc = 32'h1020; wb_valid = 1'b1; wb_idx = 5'd3; wb_data = 32'h777;
        step();
        rt_valid = 1'b0; wb_valid = 1'b0;
        chk("R7 same-cycle write hidden", 64'(fld(3)), 64'h103);
        step();
        retire(32'h1020, 0);
        chk("R7 write visible later", 64'(fld(3)), 64'h777);
        step();

        // R9: simultaneous hits, lowest first
        cfgw(3, 1, 32'h5000);
        cfgw(7, 1, 32'h5000);
        cfgw(9, 1, 32'h5000);
        retire(32'h5000, 0);
        expect_evt("R9 order 1st", 3, 32'h5000);
        step();
        expect_evt("R9 order 2nd", 7, 32'h5000);
        step();
        expect_evt("R9 order 3rd", 9, 32'h5000);
        step();
        chk("R9 drained", 64'(evt_valid), 0);

        // R9 hold under stall, R10 drops
        evt_ready = 1'b0;
        retire(32'h5000, 0);
        step(); step();
        expect_evt("R9 stall hold", 3, 32'h5000);
        retire(32'h1000, 0);
        chk("R10 drop one", 64'(drop_count), 1);
        expect_evt("R9 stall unchanged", 3, 32'h5000);
        retire(32'h5000, 0);
        chk("R10 drop three", 64'(drop_count), 4);
        evt_ready = 1'b1;
        step();
        expect_evt("R9 resume", 7, 32'h5000);
        step();
        expect_evt("R9 resume", 9, 32'h5000);
        step();
        chk("R9 resume drained", 64'(evt_valid), 0);

        // R10 boundary: last event accepted in the same cycle as a new hit
        retire(32'h1000, 0);
        expect_evt("R10 boundary first", 0, 32'h1000);
        retire(32'h1010, 0);
        expect_evt("R10 boundary accepted", 1, 32'h1010);
        chk("R10 boundary no drop", 64'(drop_count), 4);
        step();

        // R10 saturation
        evt_ready = 1'b0;
        retire(32'h1000, 0);
        for (int k = 0; k < 100; k++) retire(32'h5000, 0);
        chk("R10 saturated", 64'(drop_count), 255);
        expect_evt("R10 pending kept", 0, 32'h1000);
        evt_ready = 1'b1;
        step();
        chk("R10 drained", 64'(evt_valid), 0);

        // R3 / R4: single call and return
        cfgw(10, 1, 32'h2000);
        cfgw(10, 0, 32'h3);
        retire(32'h2000, 32'h3004);
        chk("R3 entry silent", 64'(evt_valid), 0);
        retire(32'h3004, 0);
        expect_evt("R4 return", 10, 32'h3004);
        step();
        retire(32'h3004, 0);
        chk("R4 popped", 64'(evt_valid), 0);

        // R5: nesting
        cfgw(11, 1, 32'h2100);
        cfgw(11, 0, 32'h3);
        retire(32'h2000, 32'h3100);
        retire(32'h2100, 32'h3200);
        retire(32'h3100, 0);
        chk("R5 inner first", 64'(evt_valid), 0);
        retire(32'h3200, 0);
        expect_evt("R5 inner return", 11, 32'h3200);
        step();
        retire(32'h3100, 0);
        expect_evt("R5 outer return", 10, 32'h3100);
        step();

        // R6: overflow
        for (int k = 0; k < 4; k++) retire(32'h2000, 32'h4000 + 32'(4 * k));
        chk("R6 full no overflow", 64'(stk_overflow), 0);
        retire(32'h2000, 32'h4010);
        chk("R6 overflow set", 64'(stk_overflow), 1);
        for (int k = 3; k >= 0; k--) begin
            retire(32'h4000 + 32'(4 * k), 0);
            expect_evt("R6 kept entries", 10, 32'h4000 + 32'(4 * k));
            step();
        end
        retire(32'h4010, 0);
        chk("R6 dropped push", 64'(evt_valid), 0);
        chk("R6 sticky", 64'(stk_overflow), 1);

        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule